// File: doc/BRIEF.md
# Two-Way Latched Bus Transceiver

This block joins two parallel buses, called side A and side B, through two separate storage paths. One path carries data from A towards B, the other from B towards A. Each path owns a storage register and three active-low controls: a path enable, a load strobe and an output enable. Because the paths share nothing, the block can capture a word travelling one way while it drives or holds a word travelling the other way.

Storage is modelled as clocked registers. While a path is enabled and its load strobe is low, the path is transparent. The destination side then shows the live source value in the same cycle, and the register copies that value at every rising clock edge. When the load strobe goes high, the register keeps the value it sampled at the last edge on which the path was loading.

Neither side is driven as a tri-state net. Each side has a value output and a per-bit drive-enable output, so that the integration level can map the pair onto pad buffers. The value output reads zero whenever the drive-enable is off. A synchronous, active-high reset clears both registers.

Top module: `dual_latch_xcvr`

## Requirements
- R1: A clock edge with `rst` high clears both stored words to zero. Once `rst` is low, a path that drives without loading presents 0x00.
- R2: While a path's enable is high, its destination drive-enable bits are all 0 and its register does not change, whatever its load strobe and output enable do.
- R3: While a path's enable and load strobe are both low, its register is transparent. When that path drives, its destination value equals the current source value in the same cycle.
- R4: The stored word equals the source value at the last rising clock edge at which the enable and load strobe were both low. While the load strobe is high, source changes do not reach the destination.
- R5: While a path's output enable is high, its destination drive-enable bits are all 0. The stored word is unaffected, and it reappears once the output enable returns low.
- R6: The destination drive-enable bits are all 1 exactly when the path's enable and output enable are both low. When driven, bit i of the destination equals bit i of the stored or transparent word, with no inversion and no reordering.
- R7: The B-to-A path behaves like the A-to-B path, using its own three controls. Neither path's controls affect the other path's register or outputs.
- R8: While a side's drive-enable bits are 0, that side's value output is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for both registers |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | W | Value seen on side A (source for A-to-B) |
| b_in | input | W | Value seen on side B (source for B-to-A) |
| en_ab_n | input | 1 | A-to-B path enable, active low |
| ld_ab_n | input | 1 | A-to-B load strobe, active low |
| oe_ab_n | input | 1 | A-to-B output enable, active low |
| en_ba_n | input | 1 | B-to-A path enable, active low |
| ld_ba_n | input | 1 | B-to-A load strobe, active low |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| a_out | output | W | Value driven onto side A by the B-to-A path |
| a_oe | output | W | Per-bit drive-enable for side A |
| b_out | output | W | Value driven onto side B by the A-to-B path |
| b_oe | output | W | Per-bit drive-enable for side B |

## Verification
A corrupted or wrongly loaded register stays hidden until its path is enabled and driving with the load strobe high. From that cycle onward the destination value is wrong, and it stays wrong until the next load. The bench therefore reads every stored word back through a non-transparent drive phase right after the cycles that could have disturbed it. A wrong drive decode shows up in the same cycle as the control change, as drive-enable bits that are set, cleared or mixed when they should not be.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int DIRS   = 2;
    localparam int DIR_AB = 0;
    localparam int DIR_BA = 1;

    // Raw active-low controls of one direction
    typedef struct packed {
        logic en_n;
        logic ld_n;
        logic oe_n;
    } dir_ctl_t;

    // Decoded, active-high mode of one direction
    typedef struct packed {
        logic load;
        logic pass;
        logic drive;
    } dir_mode_t;

    function automatic dir_mode_t decode_ctl(input dir_ctl_t c);
        dir_mode_t m;
        m.load  = !c.en_n && !c.ld_n;
        m.pass  = !c.en_n && !c.ld_n;
        m.drive = !c.en_n && !c.oe_n;
        return m;
    endfunction

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
    parameter int W = 8
) (
    input  logic         pass,
    input  logic         drive,
    input  logic [W-1:0] live,
    input  logic [W-1:0] held,
    output logic [W-1:0] val,
    output logic [W-1:0] oe
);

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            always_comb begin
                oe[i]  = drive;
                val[i] = drive ? (pass ? live[i] : held[i]) : 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  dir_ctl_t     ctl,
    input  logic [W-1:0] src,
    output logic [W-1:0] dst_val,
    output logic [W-1:0] dst_oe
);

    dir_mode_t    mode;
    logic [W-1:0] held;

    assign mode = decode_ctl(ctl);

    xcvr_store #(.W(W)) u_store (
        .clk  (clk),
        .rst  (rst),
        .load (mode.load),
        .d    (src),
        .q    (held)
    );

    xcvr_drive #(.W(W)) u_drive (
        .pass  (mode.pass),
        .drive (mode.drive),
        .live  (src),
        .held  (held),
        .val   (dst_val),
        .oe    (dst_oe)
    );

endmodule

// File: rtl/dual_latch_xcvr.sv
module dual_latch_xcvr
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         en_ab_n,
    input  logic         ld_ab_n,
    input  logic         oe_ab_n,
    input  logic         en_ba_n,
    input  logic         ld_ba_n,
    input  logic         oe_ba_n,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);

    dir_ctl_t     ctl_v [DIRS];
    logic [W-1:0] src_v [DIRS];
    logic [W-1:0] val_v [DIRS];
    logic [W-1:0] oe_v  [DIRS];

    assign ctl_v[DIR_AB] = '{en_n: en_ab_n, ld_n: ld_ab_n, oe_n: oe_ab_n};
    assign ctl_v[DIR_BA] = '{en_n: en_ba_n, ld_n: ld_ba_n, oe_n: oe_ba_n};
    assign src_v[DIR_AB] = a_in;
    assign src_v[DIR_BA] = b_in;

    genvar d;
    generate
        for (d = 0; d < DIRS; d++) begin : g_dir
            xcvr_path #(.W(W)) u_path (
                .clk     (clk),
                .rst     (rst),
                .ctl     (ctl_v[d]),
                .src     (src_v[d]),
                .dst_val (val_v[d]),
                .dst_oe  (oe_v[d])
            );
        end
    endgenerate

    assign b_out = val_v[DIR_AB];
    assign b_oe  = oe_v[DIR_AB];
    assign a_out = val_v[DIR_BA];
    assign a_oe  = oe_v[DIR_BA];

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic         en_ab_n,
    input logic         ld_ab_n,
    input logic         oe_ab_n,
    input logic         en_ba_n,
    input logic         ld_ba_n,
    input logic         oe_ba_n,
    input logic [W-1:0] a_out,
    input logic [W-1:0] a_oe,
    input logic [W-1:0] b_out,
    input logic [W-1:0] b_oe
);

    logic hold_ab, hold_ba;
    assign hold_ab = !en_ab_n && ld_ab_n && !oe_ab_n;
    assign hold_ba = !en_ba_n && ld_ba_n && !oe_ba_n;

    AST_AB_DISABLED_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        en_ab_n |-> (b_oe == '0));  // R2
    AST_BA_DISABLED_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        en_ba_n |-> (a_oe == '0));  // R7
    AST_AB_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
        (!en_ab_n && !ld_ab_n && !oe_ab_n) |-> (b_out == a_in));  // R3
    AST_BA_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
        (!en_ba_n && !ld_ba_n && !oe_ba_n) |-> (a_out == b_in));  // R7
    AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (hold_ab && !$past(rst) && $past(!en_ab_n && !ld_ab_n)) |-> (b_out == $past(a_in)));  // R4
    AST_AB_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (hold_ab && !$past(rst) && $past(hold_ab)) |-> $stable(b_out));  // R4
    AST_BA_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (hold_ba && !$past(rst) && $past(hold_ba)) |-> $stable(a_out));  // R7
    AST_AB_OE_OFF: assert property (@(posedge clk) disable iff (rst)
        oe_ab_n |-> (b_oe == '0));  // R5
    AST_DRV_ALL_OR_NONE: assert property (@(posedge clk) disable iff (rst)
        ((b_oe == '0) || (b_oe == '1)) && ((a_oe == '0) || (a_oe == '1)));  // R6
    AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((b_oe == '0) |-> (b_out == '0)) and ((a_oe == '0) |-> (a_out == '0)));  // R8

endmodule

bind dual_latch_xcvr xcvr_checker #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .a_in    (a_in),
    .b_in    (b_in),
    .en_ab_n (en_ab_n),
    .ld_ab_n (ld_ab_n),
    .oe_ab_n (oe_ab_n),
    .en_ba_n (en_ba_n),
    .ld_ba_n (ld_ba_n),
    .oe_ba_n (oe_ba_n),
    .a_out   (a_out),
    .a_oe    (a_oe),
    .b_out   (b_out),
    .b_oe    (b_oe)
);

// File: tb/dual_latch_xcvr_test.sv
module dual_latch_xcvr_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         en_ab_n = 1'b1, ld_ab_n = 1'b1, oe_ab_n = 1'b1;
    logic         en_ba_n = 1'b1, ld_ba_n = 1'b1, oe_ba_n = 1'b1;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    dual_latch_xcvr #(.W(W)) uut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .en_ab_n(en_ab_n), .ld_ab_n(ld_ab_n), .oe_ab_n(oe_ab_n),
        .en_ba_n(en_ba_n), .ld_ba_n(ld_ba_n), .oe_ba_n(oe_ba_n),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    // controls packed as {en_n, ld_n, oe_n}
    typedef struct packed {
        logic [7:0] a;
        logic [7:0] b;
        logic [2:0] ab;
        logic [2:0] ba;
        logic [7:0] xb;
        logic       xbd;
        logic [7:0] xa;
        logic       xad;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'h11, 8'h22, 3'b010, 3'b010, 8'h00, 1'b1, 8'h00, 1'b1},  // R1 zero after reset
        '{8'h3C, 8'h22, 3'b000, 3'b100, 8'h3C, 1'b1, 8'h00, 1'b0},  // R3 transparent, R2 off
        '{8'hA5, 8'h99, 3'b010, 3'b111, 8'h3C, 1'b1, 8'h00, 1'b0},  // R4 held, R2 no load
        '{8'hFF, 8'h5A, 3'b011, 3'b001, 8'h00, 1'b0, 8'h00, 1'b0},  // R5 oe off, R8 zero
        '{8'h00, 8'h00, 3'b010, 3'b010, 8'h3C, 1'b1, 8'h5A, 1'b1},  // R5 word back, R7 loaded
        '{8'h77, 8'h81, 3'b100, 3'b000, 8'h00, 1'b0, 8'h81, 1'b1},  // R2 disabled, R7 pass
        '{8'h00, 8'h00, 3'b010, 3'b010, 8'h3C, 1'b1, 8'h81, 1'b1},  // R2 kept, R4 capture
        '{8'hC3, 8'h00, 3'b000, 3'b010, 8'hC3, 1'b1, 8'h81, 1'b1},  // R7 independent
        '{8'h00, 8'h00, 3'b010, 3'b010, 8'hC3, 1'b1, 8'h81, 1'b1}   // R6 non-inverting
    };

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_ctl(input logic [2:0] ab, input logic [2:0] ba);
        {en_ab_n, ld_ab_n, oe_ab_n} = ab;
        {en_ba_n, ld_ba_n, oe_ba_n} = ba;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        // R2: during reset all controls high, no drive
        @(negedge clk);
        #1 chk("R2 reset drive", b_oe | a_oe, '0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            a_in = VECS[i].a;
            b_in = VECS[i].b;
            set_ctl(VECS[i].ab, VECS[i].ba);
            #1;
            chk($sformatf("R6 vec%0d b_out", i), b_out, VECS[i].xb);
            chk($sformatf("R6 vec%0d b_oe", i),  b_oe,  {W{VECS[i].xbd}});
            chk($sformatf("R7 vec%0d a_out", i), a_out, VECS[i].xa);
            chk($sformatf("R7 vec%0d a_oe", i),  a_oe,  {W{VECS[i].xad}});
        end

        // R6: walking one through transparent path, bit order and polarity
        for (int k = 0; k < W; k++) begin
            @(negedge clk);
            a_in = W'(1) << k;
            set_ctl(3'b000, 3'b111);
            #1 chk("R6 walk", b_out, W'(1) << k);
        end
        // R4: capture last sampled value, then source changes are ignored
        @(negedge clk);
        a_in = 8'h6E;
        set_ctl(3'b000, 3'b111);
        @(negedge clk);
        set_ctl(3'b010, 3'b111);
        a_in = 8'h19;
        #1 chk("R4 capture", b_out, 8'h6E);
        @(negedge clk);
        a_in = 8'hE2;
        #1 chk("R4 ignore", b_out, 8'h6E);

        // R1: mid-run reset clears both words
        @(negedge clk);
        rst = 1'b1;
        set_ctl(3'b111, 3'b111);
        @(negedge clk);
        rst = 1'b0;
        set_ctl(3'b010, 3'b010);
        #1;
        chk("R1 b word", b_out, '0);
        chk("R1 a word", a_out, '0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule